// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter Stage

This block is a synchronous binary up-counter, four bits wide by default, with a parallel preset. Every state bit updates on the same rising clock edge. An active-low load input copies a data word into the counter. An active-low clear input forces the count to zero. An elaboration-time parameter decides whether the clear acts at once (asynchronous) or at the next rising edge (synchronous).

Counting needs two enables, P and T, both high. A ripple-carry output is high while the count is all ones and T is high. Stages are chained by tying each stage's carry to the next stage's T input, and its P input as well if needed. Because the carry has no register, every stage in the chain advances on the same edge.

With the synchronous clear, a wrap below the full range is easy to build. An outside decode of the wanted final count drives the clear input, and the counter returns to zero on the following edge.

Top module: `pcnt_stage`

## Requirements
- R1: While `rst_n` is low, `q` is all zeros. After `rst_n` returns high, the counter starts from zero.
- R2: When `clr_n` and `load_n` are high and `ena_p` and `ena_t` are both high at a rising edge, `q` increments by one. From all ones it wraps to all zeros.
- R3: When `clr_n` and `load_n` are high and either `ena_p` or `ena_t` is low at a rising edge, `q` keeps its value.
- R4: When `load_n` is low and `clr_n` is high at a rising edge, `q` takes the value of `din`, whatever the levels of `ena_p` and `ena_t`.
- R5: With `CLEAR_ASYNC` = 0, a low `clr_n` at a rising edge sets `q` to zero on that edge. This takes priority over load and count. A falling `clr_n` between edges leaves `q` unchanged until the edge.
- R6: With `CLEAR_ASYNC` = 1, `q` goes to zero as soon as `clr_n` falls, with no clock edge. It stays at zero while `clr_n` is low, whatever the load and enable inputs.
- R7: `carry` is high whenever `ena_t` is high and `q` is all ones. It follows `ena_t` in the same cycle, with no clock delay.
- R8: `carry` is low whenever `ena_t` is low or `q` is not all ones. This holds regardless of `ena_p`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, expected to be released synchronously |
| clr_n | input | 1 | Active-low clear; its timing is set by `CLEAR_ASYNC` |
| load_n | input | 1 | Active-low synchronous parallel load |
| ena_p | input | 1 | Count enable that does not reach the carry |
| ena_t | input | 1 | Count enable that also gates the carry |
| din | input | WIDTH | Parallel preset data |
| q | output | WIDTH | Current count |
| carry | output | 1 | Ripple carry, high at all ones while `ena_t` is high |

## Verification
The bench builds two stages side by side with `WIDTH` = 4: one with `CLEAR_ASYNC` = 0 and one with `CLEAR_ASYNC` = 1. Both receive the same stimulus. Driving them together shows the difference between the clear modes directly. When `clr_n` falls between edges, the asynchronous stage drops to zero at once while the synchronous stage holds its count until the edge. The four-bit width lets full wrap-around and the all-ones carry window occur within a few dozen cycles. Directed sequences are followed by a long random run in which the priority of clear over load over count is checked against a behavioural model on every clock.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;
  // Action taken by the counter register at the next rising edge
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_COUNT = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } cnt_op_e;
endpackage

// File: rtl/pcnt_decode.sv
module pcnt_decode
  import pcnt_pkg::*;
#(
  parameter bit CLEAR_ASYNC = 1'b0
) (
  input  logic    clr_n,
  input  logic    load_n,
  input  logic    ena_p,
  input  logic    ena_t,
  output cnt_op_e op
);

  logic sync_clr;

  // The synchronous clear is only decoded here in synchronous mode.
  // In asynchronous mode the register's reset path handles clear.
  generate
    if (CLEAR_ASYNC) begin : g_clr_async
      assign sync_clr = 1'b0;
    end else begin : g_clr_sync
      assign sync_clr = ~clr_n;
    end
  endgenerate

  // Priority: clear, then load, then count, then hold
  always_comb begin
    if (sync_clr) begin
      op = OP_CLEAR;
    end else if (!load_n) begin
      op = OP_LOAD;
    end else if (ena_p && ena_t) begin
      op = OP_COUNT;
    end else begin
      op = OP_HOLD;
    end
  end

endmodule

// File: rtl/pcnt_state.sv
module pcnt_state
  import pcnt_pkg::*;
#(
  parameter int unsigned WIDTH       = 4,
  parameter bit          CLEAR_ASYNC = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_n,
  input  cnt_op_e          op,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q
);

  localparam logic [WIDTH-1:0] ZERO = '0;
  localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);

  logic [WIDTH-1:0] q_r;
  logic [WIDTH-1:0] q_nxt;
  logic             upd_en;
  logic             arst_n;

  // Select which signals may clear the register without a clock
  generate
    if (CLEAR_ASYNC) begin : g_arst_clr
      assign arst_n = rst_n & clr_n;
    end else begin : g_arst_rst
      assign arst_n = rst_n;
    end
  endgenerate

  // Next-state process
  always_comb begin
    q_nxt  = q_r;
    upd_en = 1'b1;
    unique case (op)
      OP_CLEAR: q_nxt = ZERO;
      OP_LOAD:  q_nxt = din;
      OP_COUNT: q_nxt = q_r + ONE;
      default: begin
        q_nxt  = q_r;
        upd_en = 1'b0;
      end
    endcase
  end

  // Register process with explicit clock enable
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      q_r <= ZERO;
    end else if (upd_en) begin
      q_r <= q_nxt;
    end
  end

  assign q = q_r;

endmodule

// File: rtl/pcnt_carry.sv
module pcnt_carry #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] q,
  input  logic             ena_t,
  output logic             carry
);

  // AND chain over the count bits, built stage by stage
  logic [WIDTH:0] all_hi;

  assign all_hi[0] = ena_t;

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_and
      assign all_hi[i+1] = all_hi[i] & q[i];
    end
  endgenerate

  // No register: a chained stage sees it in the same cycle
  assign carry = all_hi[WIDTH];

endmodule

// File: rtl/pcnt_stage.sv
module pcnt_stage
  import pcnt_pkg::*;
#(
  parameter int unsigned WIDTH       = 4,
  parameter bit          CLEAR_ASYNC = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_n,
  input  logic             load_n,
  input  logic             ena_p,
  input  logic             ena_t,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q,
  output logic             carry
);

  cnt_op_e          op;
  logic [WIDTH-1:0] q_int;

  pcnt_decode #(
    .CLEAR_ASYNC(CLEAR_ASYNC)
  ) u_decode (
    .clr_n  (clr_n),
    .load_n (load_n),
    .ena_p  (ena_p),
    .ena_t  (ena_t),
    .op     (op)
  );

  pcnt_state #(
    .WIDTH      (WIDTH),
    .CLEAR_ASYNC(CLEAR_ASYNC)
  ) u_state (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_n (clr_n),
    .op    (op),
    .din   (din),
    .q     (q_int)
  );

  pcnt_carry #(
    .WIDTH(WIDTH)
  ) u_carry (
    .q     (q_int),
    .ena_t (ena_t),
    .carry (carry)
  );

  assign q = q_int;

endmodule

// File: rtl/pcnt_stage_chk.sv
module pcnt_stage_chk #(
  parameter int unsigned WIDTH       = 4,
  parameter bit          CLEAR_ASYNC = 1'b0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr_n,
  input logic             load_n,
  input logic             ena_p,
  input logic             ena_t,
  input logic [WIDTH-1:0] din,
  input logic [WIDTH-1:0] q,
  input logic             carry
);

  localparam logic [WIDTH-1:0] ALL_ONES = '1;

  logic [WIDTH-1:0] q_plus;
  assign q_plus = q + WIDTH'(1);

  // R1
  reset_zero_chk: assert property (@(posedge clk) !rst_n |-> q == '0);

  // R2
  count_inc_chk: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    (load_n && clr_n && ena_p && ena_t) |=> q == $past(q_plus));

  // R3
  hold_val_chk: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    (load_n && clr_n && !(ena_p && ena_t)) |=> $stable(q));

  // R4
  load_val_chk: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    (!load_n && clr_n) |=> q == $past(din));

  // R5
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> q == '0);

  // R6
  async_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (CLEAR_ASYNC && !clr_n) |-> q == '0);

  // R7
  carry_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ena_t && q == ALL_ONES) |-> carry);

  // R8
  carry_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ena_t || q != ALL_ONES) |-> !carry);

endmodule

bind pcnt_stage pcnt_stage_chk #(
  .WIDTH      (WIDTH),
  .CLEAR_ASYNC(CLEAR_ASYNC)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .clr_n  (clr_n),
  .load_n (load_n),
  .ena_p  (ena_p),
  .ena_t  (ena_t),
  .din    (din),
  .q      (q),
  .carry  (carry)
);

// File: tb/tb_pcnt_stage.sv
`timescale 1ns/1ps
module tb_pcnt_stage;

  localparam int W = 4;
  localparam int MOD = 1 << W;

  logic         clk = 1'b0;
  logic         rst_n, clr_n, load_n, ena_p, ena_t;
  logic [W-1:0] din;
  logic [W-1:0] q_s, q_a;
  logic         c_s, c_a;

  int checks = 0;
  int fails  = 0;
  int ref_s  = 0;
  int ref_a  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  pcnt_stage #(.WIDTH(W), .CLEAR_ASYNC(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .load_n(load_n),
    .ena_p(ena_p), .ena_t(ena_t), .din(din), .q(q_s), .carry(c_s));

  pcnt_stage #(.WIDTH(W), .CLEAR_ASYNC(1'b1)) dut_async (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .load_n(load_n),
    .ena_p(ena_p), .ena_t(ena_t), .din(din), .q(q_a), .carry(c_a));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Compare both stages with the reference counts
  task automatic compare(input string req);
    check({req, " q sync"},      int'(q_s), ref_s);
    check({req, " q async"},     int'(q_a), ref_a);
    check({req, " carry sync"},  int'(c_s), int'(ena_t && ref_s == MOD-1));
    check({req, " carry async"}, int'(c_a), int'(ena_t && ref_a == MOD-1));
  endtask

  function automatic int step_ref(input int cur, input bit async_mode);
    if (!rst_n) return 0;
    if (!clr_n) return 0;
    if (!load_n) return int'(din);
    if (ena_p && ena_t) return (cur + 1) % MOD;
    return cur;
  endfunction

  // One rising edge: update the reference, then compare after settling
  task automatic tick(input string req);
    @(posedge clk);
    ref_s = step_ref(ref_s, 1'b0);
    ref_a = step_ref(ref_a, 1'b1);
    #2;
    compare(req);
    @(negedge clk);
  endtask

  task automatic drive(input bit c, input bit l, input bit p, input bit t, input int d);
    clr_n = c; load_n = l; ena_p = p; ena_t = t; din = W'(d);
  endtask

  initial begin
    rst_n = 1'b0;
    drive(1, 1, 1, 1, 0);
    @(negedge clk);
    for (int i = 0; i < 3; i++) tick("R1 reset");
    rst_n = 1'b1;

    // R2 counting through wrap, R7 carry at all ones
    for (int i = 0; i < 20; i++) tick("R2/R7 count");

    // Load all ones, then hold with P low: carry stays (R7)
    drive(1, 0, 0, 0, MOD-1);
    tick("R4 load ones");
    drive(1, 1, 0, 1, 0);
    tick("R3 hold P low");
    #1; check("R7 carry with T high", int'(c_s), 1);
    // T low at all ones: no carry, no count (R8, R3)
    drive(1, 1, 1, 0, 0);
    #1; check("R8 carry T low", int'(c_s), 0);
    tick("R3/R8 hold T low");
    // T high again: carry appears without a clock edge (R7)
    ena_t = 1'b1; ena_p = 1'b0;
    #1; check("R7 carry same cycle", int'(c_a), 1);

    // R4 load over counting enables
    drive(1, 0, 1, 1, 10);
    tick("R4 load over count");
    drive(1, 0, 0, 0, 5);
    tick("R4 load enables low");
    drive(1, 1, 1, 1, 0);
    tick("R2 count after load");

    // R5 sync clear beats load and count
    drive(0, 0, 1, 1, 9);
    tick("R5 clear priority");
    drive(1, 1, 1, 1, 0);
    for (int i = 0; i < 3; i++) tick("R2 after clear");

    // R6 async clear between edges, R5 sync waits for the edge
    clr_n = 1'b0; load_n = 1'b0; din = 4'd7;
    ref_a = 0;
    #1;
    check("R6 async immediate", int'(q_a), 0);
    check("R5 sync waits edge", int'(q_s), ref_s);
    tick("R5/R6 clear held");
    drive(1, 1, 1, 1, 0);
    tick("R2 resume");

    // Random run against the model
    for (int i = 0; i < 400; i++) begin
      drive(($urandom % 8) != 0, ($urandom % 5) != 0, ($urandom % 4) != 0,
            ($urandom % 4) != 0, int'($urandom % MOD));
      if (!clr_n) ref_a = 0;
      tick("R2/R3/R4/R5 random");
    end

    // R1 reset in the middle of counting
    drive(1, 1, 1, 1, 0);
    for (int i = 0; i < 5; i++) tick("R2 pre-reset");
    rst_n = 1'b0;
    ref_s = 0; ref_a = 0;
    #1;
    check("R1 async reset sync", int'(q_s), 0);
    check("R1 async reset async", int'(q_a), 0);
    tick("R1 reset held");
    rst_n = 1'b1;
    tick("R1 restart");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule